// File: doc/BRIEF.md
# Halt-Aware Watchdog Timer

This block guards a small microcontroller core against runaway software. A free-running counter advances on ticks from one of three clock sources, chosen by a static configuration input. The sources are a slow on-chip oscillator tick, the instruction clock (the block clock divided by a fixed ratio, four by default), and a real-time-clock tick. Software must clear the counter with a clear strobe before it wraps. If the counter wraps, the block requests a reset.

The kind of reset depends on the core's state when the counter wraps. While the core runs, a wrap produces a full chip reset request and sets a sticky time-out flag. While the core is halted, a wrap produces only a warm reset request, which restores the program counter and stack pointer. When the instruction clock is the source, halt stops that clock, so the counter freezes. The two asynchronous tick inputs pass through a synchronizer and an edge detector before they are counted. A static enable turns the whole watchdog off.

Top module: `halt_wdt`

## Requirements
- R1: While rst_ni is low, full_rst_o, warm_rst_o and to_o are 0 and the counter is zero. Releasing reset leaves the counter at zero.
- R2: src_sel_i selects the counting source: 0 = slow oscillator tick, 1 = instruction clock (one tick every INSTR_DIV block cycles), 2 = real-time-clock tick, 3 = no source. Ticks on a source that is not selected have no effect.
- R3: The counter advances by one for each tick of the selected source. An asynchronous tick input counts once for each low-to-high transition, two block cycles after the edge that first samples it high. The 2^CNT_W-th tick after a clear makes the counter wrap.
- R4: A wrap while halt_i is 0 drives full_rst_o high for exactly one cycle, in the cycle after the counting edge, and sets to_o.
- R5: A wrap while halt_i is 1 drives warm_rst_o high for exactly one cycle and leaves to_o unchanged. The slow-oscillator and real-time-clock sources keep counting during halt.
- R6: full_rst_o and warm_rst_o are never high in the same cycle.
- R7: Once set, to_o stays 1 through further counting and wraps. Only clr_i or a power-on reset clears it.
- R8: A clr_i pulse while the watchdog is enabled sets the counter to zero and clears to_o. When a clear and a counting tick reach the counter on the same edge, the clear wins and no wrap occurs.
- R9: With source 1 selected and halt_i high, the counter does not advance and no reset request is issued.
- R10: With wdt_en_i low, the counter is held at zero, no reset request is issued, and clr_i has no effect on to_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (system clock) |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wdt_en_i | input | 1 | Static watchdog enable |
| src_sel_i | input | 2 | Static counting-source select |
| halt_i | input | 1 | Core halted indication |
| clr_i | input | 1 | Software clear strobe |
| slow_tick_i | input | 1 | Asynchronous slow-oscillator tick |
| rtc_tick_i | input | 1 | Asynchronous real-time-clock tick |
| full_rst_o | output | 1 | One-cycle full chip reset request |
| warm_rst_o | output | 1 | One-cycle PC/SP warm reset request |
| to_o | output | 1 | Sticky time-out flag |

## Verification
The counting function is tried with each source in turn. Slow-oscillator and real-time-clock ticks are driven one at a time, so one tick fewer than a full wrap can be compared against the exact wrap. Ticks on the unselected input are driven as well, to show that the mux ignores them. The instruction-clock source is run against a timing window, both free-running and with halt held, which tells apart "frozen by halt" from "merely slow". Halt applied during slow-oscillator counting tells a warm request from a full one. A clear that lands on the same edge as the wrapping tick, and counts left over from before a disable, show whether clear priority and the disable hold-at-zero are right.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_INSTR = 2'd1,
    SRC_RTC   = 2'd2,
    SRC_NONE  = 2'd3
  } wdt_src_e;
endpackage

// File: rtl/wdt_tick_sync.sv
// Async tick -> one-cycle pulse in clk_i domain (rising-edge detect after sync).
module wdt_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wdt_src_sel.sv
module wdt_src_sel
  import wdt_pkg::*;
#(
  parameter int unsigned INSTR_DIV   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  wdt_src_e sel_i,
  input  logic     halt_i,
  input  logic     slow_tick_i,
  input  logic     rtc_tick_i,
  output logic     tick_o
);
  localparam int unsigned DIV_W = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INSTR_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic slow_pulse, rtc_pulse, instr_pulse;

  wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_slow_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(slow_tick_i), .pulse_o(slow_pulse)
  );
  wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_rtc_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(rtc_tick_i), .pulse_o(rtc_pulse)
  );

  // instruction clock stops while the core is halted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!halt_i) div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
  end

  assign instr_pulse = (div_q == DIV_LAST) & ~halt_i;

  always_comb begin
    unique case (sel_i)
      SRC_SLOW:  tick_o = slow_pulse;
      SRC_INSTR: tick_o = instr_pulse;
      SRC_RTC:   tick_o = rtc_pulse;
      default:   tick_o = 1'b0;
    endcase
  end

  AST_INSTR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_INSTR && halt_i) |-> !tick_o); // R9
  AST_NONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_NONE) |-> !tick_o); // R2
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic halt_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic full_rst_o,
  output logic warm_rst_o,
  output logic to_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic full_q, warm_q, to_q;
  logic wrap;

  assign wrap = tick_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      warm_q <= 1'b0;
      to_q   <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      warm_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      warm_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      full_q <= wrap & ~halt_i;
      warm_q <= wrap & halt_i;
      if (wrap && !halt_i) to_q <= 1'b1;
    end
  end

  assign full_rst_o = full_q;
  assign warm_rst_o = warm_q;
  assign to_o       = to_q;

  AST_RST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_q && warm_q)); // R6
  AST_FULL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> !full_q); // R4
  AST_TO_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> to_q); // R4
  AST_WARM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |=> !warm_q); // R5
  AST_WARM_KEEPS_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && tick_i && halt_i) |=> $stable(to_q)); // R5
  AST_TO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && !(en_i && clr_i)) |=> to_q); // R7
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> (cnt_q == '0 && !to_q && !full_q && !warm_q)); // R8
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !full_q && !warm_q)); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !tick_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/halt_wdt.sv
module halt_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned INSTR_DIV   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wdt_en_i,
  input  logic [1:0] src_sel_i,
  input  logic       halt_i,
  input  logic       clr_i,
  input  logic       slow_tick_i,
  input  logic       rtc_tick_i,
  output logic       full_rst_o,
  output logic       warm_rst_o,
  output logic       to_o
);
  logic tick;

  wdt_src_sel #(.INSTR_DIV(INSTR_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (wdt_src_e'(src_sel_i)),
    .halt_i      (halt_i),
    .slow_tick_i (slow_tick_i),
    .rtc_tick_i  (rtc_tick_i),
    .tick_o      (tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (wdt_en_i),
    .halt_i     (halt_i),
    .clr_i      (clr_i),
    .tick_i     (tick),
    .full_rst_o (full_rst_o),
    .warm_rst_o (warm_rst_o),
    .to_o       (to_o)
  );
endmodule

// File: tb/halt_wdt_tb_top.sv
module halt_wdt_tb_top;
  localparam int unsigned CW   = 4;
  localparam int unsigned WRAP = 1 << CW;
  localparam int K_FULL = 1;
  localparam int K_WARM = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wdt_en_i = 1'b1;
  logic [1:0] src_sel_i = 2'd0;
  logic halt_i = 1'b0;
  logic clr_i = 1'b0;
  logic slow_tick_i = 1'b0;
  logic rtc_tick_i = 1'b0;
  logic full_rst_o, warm_rst_o, to_o;

  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  string cur_req = "R1";
  logic prev_pulse = 1'b0;

  always #5 clk_i = ~clk_i;

  halt_wdt #(.CNT_W(CW), .INSTR_DIV(4), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdt_en_i(wdt_en_i), .src_sel_i(src_sel_i),
    .halt_i(halt_i), .clr_i(clr_i), .slow_tick_i(slow_tick_i), .rtc_tick_i(rtc_tick_i),
    .full_rst_o(full_rst_o), .warm_rst_o(warm_rst_o), .to_o(to_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected reset kinds as pulses appear
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int kind;
      kind = full_rst_o ? K_FULL : (warm_rst_o ? K_WARM : 0);
      if (full_rst_o && warm_rst_o) check(1'b0, "R6", 3, 1);
      if (prev_pulse && kind != 0) check(1'b0, "R4/R5 width", 2, 1);
      if (kind != 0) begin
        if (exp_q.size() == 0) check(1'b0, cur_req, kind, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(kind == e, cur_req, kind, e);
        end
      end
      prev_pulse = (kind != 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic tick_slow();
    slow_tick_i = 1'b1; cyc(1); slow_tick_i = 1'b0; cyc(1);
  endtask

  task automatic tick_rtc();
    rtc_tick_i = 1'b1; cyc(1); rtc_tick_i = 1'b0; cyc(1);
  endtask

  task automatic do_clr();
    clr_i = 1'b1; cyc(1); clr_i = 1'b0; cyc(1);
  endtask

  task automatic expect_and_tick(input int kind, input bit rtc);
    exp_q.push_back(kind);
    if (rtc) tick_rtc(); else tick_slow();
    cyc(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    check(full_rst_o == 0 && warm_rst_o == 0 && to_o == 0, "R1", {full_rst_o, warm_rst_o, to_o}, 0);
    rst_ni = 1'b1;
    cyc(2);

    // R3/R4: slow source, one short then the wrap
    cur_req = "R3";
    src_sel_i = 2'd0;
    for (int i = 0; i < WRAP - 1; i++) tick_slow();
    cyc(4);
    check(to_o == 0, "R3", to_o, 0);
    cur_req = "R4";
    expect_and_tick(K_FULL, 1'b0);
    check(exp_q.size() == 0, "R4", exp_q.size(), 0);
    check(to_o == 1, "R4", to_o, 1);

    // R7: TO stays set through another wrap
    cur_req = "R7";
    for (int i = 0; i < WRAP - 1; i++) tick_slow();
    expect_and_tick(K_FULL, 1'b0);
    check(exp_q.size() == 0 && to_o == 1, "R7", to_o, 1);

    // R10: leftover count, disable, clr ignored, count held zero
    cur_req = "R10";
    for (int i = 0; i < 8; i++) tick_slow();
    wdt_en_i = 1'b0;
    cyc(2);
    do_clr();
    check(to_o == 1, "R10", to_o, 1);
    for (int i = 0; i < 20; i++) tick_slow();
    cyc(4);
    wdt_en_i = 1'b1;
    cyc(2);
    for (int i = 0; i < WRAP - 1; i++) tick_slow();
    cyc(4);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    expect_and_tick(K_FULL, 1'b0);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);

    // R8: clr clears TO
    cur_req = "R8";
    do_clr();
    check(to_o == 0, "R8", to_o, 0);

    // R8: clr and wrapping tick on the same edge -> clr wins
    for (int i = 0; i < WRAP - 1; i++) tick_slow();
    slow_tick_i = 1'b1; cyc(1);
    slow_tick_i = 1'b0; cyc(1);
    clr_i = 1'b1; cyc(1);
    clr_i = 1'b0; cyc(4);
    check(to_o == 0, "R8", to_o, 0);
    for (int i = 0; i < WRAP - 1; i++) tick_slow();
    cyc(4);
    check(to_o == 0, "R8", to_o, 0);
    expect_and_tick(K_FULL, 1'b0);
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    do_clr();

    // R5: wrap while halted with slow source -> warm only, TO unchanged
    cur_req = "R5";
    halt_i = 1'b1;
    cyc(1);
    for (int i = 0; i < WRAP - 1; i++) tick_slow();
    expect_and_tick(K_WARM, 1'b0);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    check(to_o == 0, "R5", to_o, 0);
    halt_i = 1'b0;
    do_clr();

    // R2: rtc selected, slow ticks ignored
    cur_req = "R2";
    src_sel_i = 2'd2;
    cyc(2);
    for (int i = 0; i < WRAP + 4; i++) tick_slow();
    cyc(4);
    check(to_o == 0, "R2", to_o, 0);
    for (int i = 0; i < WRAP - 1; i++) tick_rtc();
    expect_and_tick(K_FULL, 1'b1);
    check(exp_q.size() == 0 && to_o == 1, "R2", to_o, 1);

    // R2: source 3 counts nothing
    src_sel_i = 2'd3;
    do_clr();
    for (int i = 0; i < WRAP + 4; i++) begin tick_slow(); tick_rtc(); end
    cyc(4);
    check(to_o == 0, "R2", to_o, 0);

    // R2: instruction clock source, wrap lands within window
    src_sel_i = 2'd1;
    do_clr();
    exp_q.push_back(K_FULL);
    cyc(4 * (WRAP - 1) - 6);
    check(exp_q.size() == 1, "R2", exp_q.size(), 1);
    cyc(16);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);

    // R9: instruction clock frozen during halt
    cur_req = "R9";
    halt_i = 1'b1;
    do_clr();
    exp_q.push_back(K_FULL);
    cyc(300);
    check(exp_q.size() == 1, "R9", exp_q.size(), 1);
    halt_i = 1'b0;
    cyc(4 * WRAP + 8);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);

    // R1/R7: power-on reset clears TO
    cur_req = "R1";
    src_sel_i = 2'd3;
    check(to_o == 1, "R7", to_o, 1);
    rst_ni = 1'b0;
    cyc(2);
    check(to_o == 0 && full_rst_o == 0, "R1", to_o, 0);
    rst_ni = 1'b1;
    cyc(2);
    check(to_o == 0, "R1", to_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule